// File: doc/BRIEF.md
# Compressed-Audio Burst Framer

This block turns a stream of 16-bit compressed-audio words into repeating data bursts for a digital audio link. Each burst opens with a four-word preamble. The first two words are fixed sync values. The third word is a burst-info word and the fourth is a payload-length word, and both come from configuration inputs. After the preamble come the payload words, taken from the input stream. Zero words then fill the burst out to the programmed repetition period. When the last word of a burst has been accepted downstream, a one-cycle completion pulse lets software load settings for the next bitstream.

The three configuration values are sampled when the first sync word of a burst is accepted. A write during a burst therefore takes effect at the following burst. The payload length is given in bits, and the framer emits one payload word for every started group of 16 bits. Both sides use valid/ready handshakes. Only payload words need input data, so sync, info, length and padding words go out without waiting on the input stream.

Top module: `bf_burst_framer`

## Requirements
- R1: After reset, the output offers the first sync word with `m_valid`=1, `burst_done` is 0 and `s_ready` is 0.
- R2: Every burst begins with word 16'hF872, followed by word 16'h4E1F.
- R3: The third burst word equals `cfg_info` and the fourth equals `cfg_len_bits`, using the values present when that burst's first word was accepted.
- R4: The payload is ceil(`cfg_len_bits`/16) words. Each is `s_data[15:0]` of one accepted input word, and bits 31:16 are ignored.
- R5: After the payload, words of value 0 are emitted until the burst holds `cfg_period` words in total.
- R6: When `cfg_period` is less than 4 plus the payload word count, the burst ends right after its last payload word and contains no zero words.
- R7: `burst_done` is high for exactly the one cycle that follows the acceptance of a burst's final word.
- R8: While `m_ready` is low, no word is consumed and the offered word is held. During the payload, `m_valid` follows `s_valid`. In every other phase, `m_valid` is 1.
- R9: Configuration changes made after a burst's first word has been accepted do not affect that burst. They apply to the next burst.
- R10: `s_ready` is high only while a payload word is due and `m_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_info | input | 16 | Burst-info word for the next burst |
| cfg_len_bits | input | 16 | Payload length in bits for the next burst |
| cfg_period | input | 16 | Burst repetition period in words |
| s_valid | input | 1 | Input stream word available |
| s_data | input | 32 | Input word, data in bits 15:0 |
| s_ready | output | 1 | Input word consumed this cycle |
| m_valid | output | 1 | Output word available |
| m_word | output | 16 | Output word |
| m_ready | input | 1 | Downstream accepts the word |
| burst_done | output | 1 | One-cycle pulse after a burst completes |

## Verification
The assertion that ties an accepted input to the output word assumes a source that respects the handshake. The assertions also assume the downstream may stall at any time, and they place no stability requirement on `s_valid` or `s_data`. The bench drives `s_valid`, `s_data` and `m_ready` with fresh random values each cycle, which stays within those assumptions. It moves the configuration inputs in the middle of bursts so that late writes are exercised. The chosen periods cover padded bursts, exactly filled bursts, overlong payloads and a zero-length payload.

// File: rtl/bf_pkg.sv
// Package: shared constants and phase type for the burst framer.
// Assumes 16-bit link words.
package bf_pkg;
    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] SYNC_A = 16'hF872;
    localparam logic [WORD_W-1:0] SYNC_B = 16'h4E1F;
    localparam int PREAMBLE_WORDS = 4;

    typedef enum logic [2:0] {
        PH_SYNC_A,
        PH_SYNC_B,
        PH_INFO,
        PH_LEN,
        PH_PAY,
        PH_PAD
    } phase_t;
endpackage

// File: rtl/bf_cfg_latch.sv
// Module: captures the burst configuration when a burst starts and derives
// the payload word count and the effective burst length.
// Assumes load pulses only on acceptance of the first sync word.
module bf_cfg_latch #(
    parameter int W     = 16,
    parameter int CNT_W = 16,
    localparam int LW   = CNT_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  info_in,
    input  logic [W-1:0]  len_in,
    input  logic [CNT_W-1:0] period_in,
    output logic [W-1:0]  info_q,
    output logic [W-1:0]  len_q,
    output logic [LW-1:0] pay_words,
    output logic [LW-1:0] burst_len
);
    logic [CNT_W-1:0] period_q;
    logic [LW-1:0]    min_len;

    // Hold the configuration for the duration of one burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q   <= '0;
            len_q    <= '0;
            period_q <= CNT_W'(bf_pkg::PREAMBLE_WORDS);
        end else if (load) begin
            info_q   <= info_in;
            len_q    <= len_in;
            period_q <= period_in;
        end
    end

    // Round the bit length up to whole words, and never let the burst end inside the payload.
    always_comb begin
        pay_words = LW'((({1'b0, len_q}) + (W + 1)'(W - 1)) / (W + 1)'(W));
        min_len   = pay_words + LW'(bf_pkg::PREAMBLE_WORDS);
        burst_len = ({1'b0, period_q} > min_len) ? {1'b0, period_q} : min_len;
    end
endmodule

// File: rtl/bf_seq.sv
// Module: word-position counter within a burst. Decodes the phase and
// flags burst completion.
// Assumes burst_len >= 4 and stable once the position passes the sync words.
module bf_seq #(
    parameter int CNT_W = 16,
    localparam int LW   = CNT_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [LW-1:0] pay_words,
    input  logic [LW-1:0] burst_len,
    output logic [LW-1:0] pos,
    output bf_pkg::phase_t phase,
    output logic          done
);
    import bf_pkg::*;

    logic last;

    // Map the position onto preamble, payload or padding.
    always_comb begin
        if (pos == LW'(0))      phase = PH_SYNC_A;
        else if (pos == LW'(1)) phase = PH_SYNC_B;
        else if (pos == LW'(2)) phase = PH_INFO;
        else if (pos == LW'(3)) phase = PH_LEN;
        else if (pos < pay_words + LW'(PREAMBLE_WORDS)) phase = PH_PAY;
        else                    phase = PH_PAD;
        last = (pos == burst_len - LW'(1));
    end

    // Step the position on each accepted word and wrap at the end of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            done <= 1'b0;
        end else begin
            done <= adv && last;
            if (adv) pos <= last ? '0 : pos + LW'(1);
        end
    end

    AST_POS_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= LW'(3)) |-> (pos < burst_len)); // R5
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos)); // R8
endmodule

// File: rtl/bf_burst_framer.sv
// Module: top of the burst framer. Selects the link word for the current
// phase and applies the valid/ready rules on both sides.
// Assumes stream data is LSB-justified in s_data.
module bf_burst_framer #(
    parameter int IN_W  = 32,
    parameter int CNT_W = 16,
    localparam int W    = bf_pkg::WORD_W,
    localparam int LW   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     cfg_info,
    input  logic [W-1:0]     cfg_len_bits,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             s_valid,
    input  logic [IN_W-1:0]  s_data,
    output logic             s_ready,
    output logic             m_valid,
    output logic [W-1:0]     m_word,
    input  logic             m_ready,
    output logic             burst_done
);
    import bf_pkg::*;

    logic [W-1:0]  info_q, len_q;
    logic [LW-1:0] pay_words, burst_len, pos;
    phase_t        phase;
    logic          adv, load;

    bf_cfg_latch #(.W(W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .info_in(cfg_info), .len_in(cfg_len_bits), .period_in(cfg_period),
        .info_q(info_q), .len_q(len_q),
        .pay_words(pay_words), .burst_len(burst_len)
    );

    bf_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .pay_words(pay_words), .burst_len(burst_len),
        .pos(pos), .phase(phase), .done(burst_done)
    );

    // Choose the outgoing word and the handshake for the current phase.
    always_comb begin
        m_valid = 1'b1;
        case (phase)
            PH_SYNC_A: m_word = SYNC_A;
            PH_SYNC_B: m_word = SYNC_B;
            PH_INFO:   m_word = info_q;
            PH_LEN:    m_word = len_q;
            PH_PAY: begin
                m_word  = s_data[W-1:0];
                m_valid = s_valid;
            end
            default:   m_word = '0;
        endcase
        s_ready = (phase == PH_PAY) && m_ready;
        adv     = m_valid && m_ready;
        load    = adv && (phase == PH_SYNC_A);
    end

    AST_PAYLOAD_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |-> (m_word == s_data[W-1:0])); // R4
    AST_PAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && pos >= LW'(4) && pos >= pay_words + LW'(4)) |-> (m_word == '0)); // R5
    AST_DONE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (pos == '0 && $past(m_valid && m_ready))); // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pos >= LW'(2)) |-> ($stable(info_q) && $stable(len_q))); // R9
    AST_FIRST_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> (m_valid && m_word == SYNC_A)); // R2
endmodule

// File: tb/sim_bf_burst_framer.sv
module sim_bf_burst_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_info = 16'h0, cfg_len_bits = 16'h0, cfg_period = 16'd4;
    logic        s_valid = 1'b0, m_ready = 1'b0;
    logic [31:0] s_data = 32'h0;
    logic        s_ready, m_valid, burst_done;
    logic [15:0] m_word;

    int compared = 0, mismatched = 0, cycles = 0;
    // reference model state
    int mpos = 0, mlen = 4, mpw = 0, mper = 4;
    int minfo = 0, mlenb = 0;
    bit mdone = 0;

    always #10 clk = ~clk;

    bf_burst_framer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_info(cfg_info), .cfg_len_bits(cfg_len_bits),
        .cfg_period(cfg_period), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .m_valid(m_valid), .m_word(m_word), .m_ready(m_ready), .burst_done(burst_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // Compare all outputs against the model, then advance the model by the coming edge.
    task automatic step();
        int ev, ew;
        string wt;
        bit pay;
        pay = (mpos >= 4) && (mpos < 4 + mpw);
        ev  = pay ? int'(s_valid) : 1;
        if (mpos == 0)      begin ew = 16'hF872; wt = "R2"; end
        else if (mpos == 1) begin ew = 16'h4E1F; wt = "R2"; end
        else if (mpos == 2) begin ew = minfo; wt = (minfo != cfg_info) ? "R9" : "R3"; end
        else if (mpos == 3) begin ew = mlenb; wt = (mlenb != cfg_len_bits) ? "R9" : "R3"; end
        else if (pay)       begin ew = int'(s_data[15:0]); wt = "R4"; end
        else                begin ew = 0; wt = "R5"; end
        chk("R8 m_valid", m_valid, ev);
        if (ev == 1) chk(wt, m_word, ew);
        chk("R10 s_ready", s_ready, int'(pay && m_ready));
        chk((mlen > mper) ? "R6 burst_done" : "R7 burst_done", burst_done, mdone);
        mdone = 0;
        if (ev == 1 && m_ready) begin
            if (mpos == 0) begin
                minfo = cfg_info; mlenb = cfg_len_bits; mper = cfg_period;
                mpw = (cfg_len_bits + 15) / 16;
                mlen = (mper > 4 + mpw) ? mper : 4 + mpw;
            end
            if (mpos == mlen - 1) begin mpos = 0; mdone = 1; end
            else mpos++;
        end
    endtask

    task automatic run(input int n, input int info, input int lenb, input int per);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cycles++;
            if (i == n / 2) begin
                cfg_info = 16'(info + 16'h0101); cfg_len_bits = 16'(lenb + 16); cfg_period = 16'(per + 1);
            end else if (i == 0) begin
                cfg_info = 16'(info); cfg_len_bits = 16'(lenb); cfg_period = 16'(per);
            end
            s_valid = ($urandom % 4) != 0;
            s_data  = $urandom;
            m_ready = ($urandom % 3) != 0;
            #1;
            step();
        end
    endtask

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 m_valid", m_valid, 1);
        chk("R1 m_word", m_word, 16'hF872);
        chk("R1 burst_done", burst_done, 0);
        chk("R1 s_ready", s_ready, 0);
        run(3000, 16'h0015, 64, 12);   // padded bursts
        run(3000, 16'h0007, 0, 6);     // empty payload
        run(3000, 16'h0011, 17, 5);    // R6 overlong payload
        run(3000, 16'h0003, 40, 7);    // exact fit
        run(3000, 16'h0101, 1, 4);     // one word, period at minimum
        run(3000, 16'h00AA, 200, 30);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule